// File: doc/BRIEF.md
# Test Plan Sequencer with Functional/Test Control Selection

This block sits between a functional controller and a data path as the driver of the data path's control line register. In normal operation it passes the functional controller's control vector through the register and holds the control bits of the added test elements at zero. In test operation it plays out a stored plan instead. A plan is a short series of control vectors that first steers two-pattern data from primary inputs into target registers, then steers the captured response from a register to a primary output.

The plan to play is chosen by a small index register. That register is loaded from the index bits of a shared data-path input while the index-load pin is high. Its width is the base-2 logarithm of the plan count, rounded up. The control line register loads only while the index-load pin is low, and a shift pin freezes both the register and the plan position while scan shifting is under way. Test plans are applied one index at a time: software-free test equipment loads an index, runs the plan to its done flag, then loads the next index. Plan vectors and plan lengths are parameters.

Top module: `test_plan_ctrl`

## Requirements
- R1: After reset `ctrlOut` is all zero, `planDone` is 0, and the index register holds plan 0 at step 0.
- R2: In a cycle with `idxLoadMode`=1, the index register captures `idxIn` (IDX_W = ceil(log2 NUM_PLANS) bits), the plan position returns to step 0, and `planDone` clears. With back-to-back loads, the last one wins.
- R3: In a cycle with `idxLoadMode`=1, `ctrlOut` keeps its value.
- R4: In each cycle with `testMode`=1, `idxLoadMode`=0, `shiftMode`=0 and `planDone`=0, `ctrlOut` takes the next vector of the selected plan, in step order from step 0. The plan position then advances.
- R5: `planDone` rises on the same edge that the plan's last vector enters `ctrlOut`. While it stays high and test running continues, `ctrlOut` keeps that final vector.
- R6: In a cycle with `shiftMode`=1 and `idxLoadMode`=0, `ctrlOut`, `planDone` and the plan position keep their values.
- R7: In a cycle with `testMode`=0, `idxLoadMode`=0 and `shiftMode`=0 (all mode pins low is normal operation), `ctrlOut[FUNC_W-1:0]` takes `funcCtrl` and the test-element bits `ctrlOut[CTRL_W-1:FUNC_W]` become zero. The plan position does not move.
- R8: Loading an index of NUM_PLANS or above sets `planDone` on that edge, and test running then drives `ctrlOut` to all zero.
- R9: After leaving test mode in the middle of a plan, the plan resumes at the step where it stopped when test mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idxLoadMode | input | 1 | 1: load the plan index; 0: load the control line register |
| testMode | input | 1 | 1: control from plan generator; 0: control from functional controller |
| shiftMode | input | 1 | 1: scan shift under way, control register and plan frozen |
| idxIn | input | IDX_W | Index bits of the shared data-path input |
| funcCtrl | input | FUNC_W | Control vector from the functional controller |
| ctrlOut | output | CTRL_W | Control line register to the data path (upper DFT_W bits drive test elements) |
| planDone | output | 1 | Selected plan has emitted its last vector |

## Verification
The assertions assume the mode pins are held stable in each cycle and change only between edges. They also assume every stored plan length lies between 1 and MAX_STEPS, so the last-step test is always reached. The stimulus drives pins only after the output has been sampled. It uses the default table, whose lengths are 3, 4 and 1, and reaches the one unused index code to cover the out-of-range case. The reference model holds its own copy of the plan contents and recomputes the expected register and flag on every edge from the pins alone.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // strobes from the sequencing control to the vector datapath
  typedef struct packed {
    logic clrLoad;   // control line register takes a new vector
    logic useTest;   // vector comes from the plan table
    logic blank;     // selected index has no plan: emit zero
  } tpc_strobe_t;

  // default plan table: 3 plans, 4 step slots, 8-bit vectors
  // slot (plan*4 + step) sits at bits [(plan*4+step)*8 +: 8]
  localparam logic [95:0] DEF_PLAN_VECS = {
    8'h00, 8'h00, 8'h00, 8'h7E,   // plan 2
    8'hFF, 8'h5A, 8'h18, 8'hC3,   // plan 1
    8'h00, 8'h24, 8'h42, 8'h81    // plan 0
  };

  // default lengths, 3 bits each, plan 0 in the low field
  localparam logic [8:0] DEF_PLAN_LENS = {3'd1, 3'd4, 3'd3};

endpackage

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
#(
  parameter int NUM_PLANS = 3,
  parameter int MAX_STEPS = 4,
  parameter int IDX_W     = (NUM_PLANS > 1) ? $clog2(NUM_PLANS) : 1,
  parameter int STEP_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
  parameter int LEN_W     = $clog2(MAX_STEPS + 1),
  parameter logic [NUM_PLANS*LEN_W-1:0] PLAN_LENS = DEF_PLAN_LENS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxLoadMode,
  input  logic              testMode,
  input  logic              shiftMode,
  input  logic [IDX_W-1:0]  idxIn,
  output logic [IDX_W-1:0]  idxQ,
  output logic [STEP_W-1:0] stepQ,
  output logic              doneQ,
  output tpc_strobe_t       strobe
);

  logic [LEN_W-1:0] curLen;
  logic             curInvalid;
  logic             loadInvalid;
  logic             runEn;
  logic             lastStep;

  // length of the currently selected plan
  always_comb begin
    curLen = '0;
    for (int p = 0; p < NUM_PLANS; p++) begin
      if (idxQ == IDX_W'(p)) curLen = PLAN_LENS[p*LEN_W +: LEN_W];
    end
  end

  assign curInvalid  = (32'(idxQ)  >= 32'(NUM_PLANS));
  assign loadInvalid = (32'(idxIn) >= 32'(NUM_PLANS));
  assign runEn       = testMode && !idxLoadMode && !shiftMode;
  assign lastStep    = (LEN_W'(stepQ) + LEN_W'(1)) >= curLen;

  assign strobe.clrLoad = !idxLoadMode && !shiftMode;
  assign strobe.useTest = testMode;
  assign strobe.blank   = curInvalid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      stepQ <= '0;
      doneQ <= 1'b0;
    end else if (idxLoadMode) begin
      idxQ  <= idxIn;
      stepQ <= '0;
      doneQ <= loadInvalid;
    end else if (runEn && !doneQ) begin
      if (lastStep) doneQ <= 1'b1;
      else          stepQ <= stepQ + STEP_W'(1);
    end
  end

  AST_LOAD_RESTARTS_PLAN: assert property (@(posedge clk) disable iff (!rstN)
    idxLoadMode |=> (stepQ == '0) && (idxQ == $past(idxIn))); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !idxLoadMode) |=> doneQ); // R5

  AST_BAD_INDEX_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (idxLoadMode && loadInvalid) |=> doneQ); // R8

  AST_NORMAL_KEEPS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !idxLoadMode) |=> $stable(stepQ) && $stable(doneQ)); // R9

endmodule

// File: rtl/tpc_datapath.sv
module tpc_datapath
  import tpc_pkg::*;
#(
  parameter int NUM_PLANS = 3,
  parameter int MAX_STEPS = 4,
  parameter int FUNC_W    = 6,
  parameter int DFT_W     = 2,
  parameter int CTRL_W    = FUNC_W + DFT_W,
  parameter int IDX_W     = (NUM_PLANS > 1) ? $clog2(NUM_PLANS) : 1,
  parameter int STEP_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
  parameter logic [NUM_PLANS*MAX_STEPS*CTRL_W-1:0] PLAN_VECS = DEF_PLAN_VECS
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpc_strobe_t       strobe,
  input  logic [IDX_W-1:0]  idxQ,
  input  logic [STEP_W-1:0] stepQ,
  input  logic [FUNC_W-1:0] funcCtrl,
  output logic [CTRL_W-1:0] ctrlOut
);

  logic [CTRL_W-1:0] planVec;
  logic [CTRL_W-1:0] normVec;
  logic [CTRL_W-1:0] nextVec;

  // table lookup by (plan, step)
  always_comb begin
    planVec = '0;
    for (int p = 0; p < NUM_PLANS; p++) begin
      for (int s = 0; s < MAX_STEPS; s++) begin
        if (idxQ == IDX_W'(p) && stepQ == STEP_W'(s))
          planVec = PLAN_VECS[(p*MAX_STEPS + s)*CTRL_W +: CTRL_W];
      end
    end
  end

  // normal mode: functional bits pass, test-element bits forced low
  assign normVec = {{DFT_W{1'b0}}, funcCtrl};
  assign nextVec = strobe.useTest ? (strobe.blank ? '0 : planVec) : normVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlOut <= '0;
    else if (strobe.clrLoad) ctrlOut <= nextVec;
  end

  AST_BLANK_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrLoad && strobe.useTest && strobe.blank) |=> (ctrlOut == '0)); // R8

endmodule

// File: rtl/test_plan_ctrl.sv
module test_plan_ctrl
  import tpc_pkg::*;
#(
  parameter int NUM_PLANS = 3,
  parameter int MAX_STEPS = 4,
  parameter int FUNC_W    = 6,
  parameter int DFT_W     = 2,
  parameter int CTRL_W    = FUNC_W + DFT_W,
  parameter int IDX_W     = (NUM_PLANS > 1) ? $clog2(NUM_PLANS) : 1,
  parameter int STEP_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
  parameter int LEN_W     = $clog2(MAX_STEPS + 1),
  parameter logic [NUM_PLANS*MAX_STEPS*CTRL_W-1:0] PLAN_VECS = DEF_PLAN_VECS,
  parameter logic [NUM_PLANS*LEN_W-1:0]            PLAN_LENS = DEF_PLAN_LENS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxLoadMode,
  input  logic              testMode,
  input  logic              shiftMode,
  input  logic [IDX_W-1:0]  idxIn,
  input  logic [FUNC_W-1:0] funcCtrl,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              planDone
);

  tpc_strobe_t       strobe;
  logic [IDX_W-1:0]  idxQ;
  logic [STEP_W-1:0] stepQ;

  tpc_ctrl #(
    .NUM_PLANS(NUM_PLANS), .MAX_STEPS(MAX_STEPS), .IDX_W(IDX_W),
    .STEP_W(STEP_W), .LEN_W(LEN_W), .PLAN_LENS(PLAN_LENS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .idxLoadMode(idxLoadMode), .testMode(testMode),
    .shiftMode(shiftMode), .idxIn(idxIn), .idxQ(idxQ), .stepQ(stepQ),
    .doneQ(planDone), .strobe(strobe)
  );

  tpc_datapath #(
    .NUM_PLANS(NUM_PLANS), .MAX_STEPS(MAX_STEPS), .FUNC_W(FUNC_W),
    .DFT_W(DFT_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W), .STEP_W(STEP_W),
    .PLAN_VECS(PLAN_VECS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idxQ(idxQ), .stepQ(stepQ),
    .funcCtrl(funcCtrl), .ctrlOut(ctrlOut)
  );

  AST_INDEX_LOAD_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    idxLoadMode |=> $stable(ctrlOut)); // R3

  AST_SHIFT_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (shiftMode && !idxLoadMode) |=> $stable(ctrlOut) && $stable(planDone)); // R6

  AST_NORMAL_DFT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !idxLoadMode && !shiftMode)
      |=> (ctrlOut[CTRL_W-1:FUNC_W] == '0) && (ctrlOut[FUNC_W-1:0] == $past(funcCtrl))); // R7

endmodule

// File: tb/tb_test_plan_ctrl.sv
module tb_test_plan_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idxLoadMode = 1'b0;
  logic       testMode = 1'b0;
  logic       shiftMode = 1'b0;
  logic [1:0] idxIn = '0;
  logic [5:0] funcCtrl = '0;
  logic [7:0] ctrlOut;
  logic       planDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int         mIdx = 0;
  int         mStep = 0;
  bit         mDone = 0;
  logic [7:0] mCtrl = '0;

  always #4 clk = ~clk;   // 125 MHz

  test_plan_ctrl dut (
    .clk(clk), .rstN(rstN), .idxLoadMode(idxLoadMode), .testMode(testMode),
    .shiftMode(shiftMode), .idxIn(idxIn), .funcCtrl(funcCtrl),
    .ctrlOut(ctrlOut), .planDone(planDone)
  );

  function automatic logic [7:0] refVec(int p, int s);
    case (p)
      0: case (s) 0: return 8'h81; 1: return 8'h42; 2: return 8'h24; default: return 8'h00; endcase
      1: case (s) 0: return 8'hC3; 1: return 8'h18; 2: return 8'h5A; 3: return 8'hFF; default: return 8'h00; endcase
      2: return (s == 0) ? 8'h7E : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int refLen(int p);
    case (p) 0: return 3; 1: return 4; 2: return 1; default: return 0; endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (ctrlOut !== mCtrl || planDone !== mDone) begin
      errors++;
      $display("FAIL %s ctrlOut=%h exp %h planDone=%b exp %b", tag, ctrlOut, mCtrl, planDone, mDone);
    end
  endtask

  task automatic tick(input logic lh, input logic tn, input logic sp,
                      input logic [1:0] ix, input logic [5:0] fc, input string tag);
    idxLoadMode = lh; testMode = tn; shiftMode = sp; idxIn = ix; funcCtrl = fc;
    @(posedge clk);
    if (lh) begin
      mIdx = ix; mStep = 0; mDone = (ix >= 3);
    end else if (!sp) begin
      if (tn) begin
        mCtrl = (mIdx >= 3) ? 8'h00 : refVec(mIdx, mStep);
        if (!mDone) begin
          if (mStep + 1 >= refLen(mIdx)) mDone = 1;
          else mStep++;
        end
      end else begin
        mCtrl = {2'b00, fc};
      end
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #10;
    compare("R1 reset");
    @(posedge clk); #2; rstN = 1'b1;
    // R1: plan 0 step 0 selected out of reset
    tick(0, 1, 0, 2'd0, 6'h00, "R1 plan0 after reset");
    // R7: normal operation, functional vectors pass, DFT bits low
    tick(0, 0, 0, 2'd0, 6'h3F, "R7");
    tick(0, 0, 0, 2'd0, 6'h15, "R7");
    tick(0, 0, 0, 2'd0, 6'h2A, "R7");
    // R2/R3: index load restarts plan 0; ctrlOut holds
    tick(1, 1, 0, 2'd0, 6'h00, "R3 hold during load");
    for (int i = 0; i < 5; i++) tick(0, 1, 0, 2'd0, 6'h11, "R4 R5 plan0");
    // R2: back-to-back loads, last wins (plan 1)
    tick(1, 0, 0, 2'd2, 6'h00, "R2 first load");
    tick(1, 1, 0, 2'd1, 6'h00, "R2 last load wins");
    tick(0, 1, 0, 2'd0, 6'h00, "R4 plan1");
    tick(0, 1, 0, 2'd0, 6'h00, "R4 plan1");
    // R6: shift freezes
    for (int i = 0; i < 3; i++) tick(0, 1, 1, 2'd0, 6'h0F, "R6 shift hold");
    tick(0, 0, 1, 2'd0, 6'h0F, "R6 shift hold normal");
    // R9: leave test mode mid-plan then resume
    tick(0, 0, 0, 2'd0, 6'h33, "R9 normal mid-plan");
    tick(0, 0, 0, 2'd0, 6'h0C, "R9 normal mid-plan");
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 2'd0, 6'h00, "R9 R5 resume plan1");
    // single-step plan
    tick(1, 1, 0, 2'd2, 6'h00, "R2 load plan2");
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 2'd0, 6'h00, "R5 plan2");
    // R8: out-of-range index
    tick(1, 1, 0, 2'd3, 6'h00, "R8 load bad index");
    for (int i = 0; i < 2; i++) tick(0, 1, 0, 2'd0, 6'h00, "R8 blank");
    tick(0, 0, 0, 2'd0, 6'h21, "R7 normal after bad");
    // R2: reload valid index clears done
    tick(1, 1, 0, 2'd0, 6'h00, "R2 reload clears done");
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 2'd0, 6'h00, "R4 plan0 again");
    tick(0, 0, 0, 2'd0, 6'h00, "R7 all pins low");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule